// File: doc/BRIEF.md
# Pipelined Floating-Point Adder/Subtractor

This block adds or subtracts two binary floating-point operands in four registered
segments. The first segment picks the larger exponent and the shift distance, the
second lines up the smaller operand's mantissa, the third combines the two magnitudes,
and the fourth normalizes the result. A new operation can enter on every clock, and
each result leaves four cycles after it entered.

Each operand has three parts. A sign bit is 1 for negative. An unsigned exponent
field `e` of `EXP_W` bits is used as is, with no bias. A fraction `m` of `MAN_W` bits
has its binary point left of the most significant bit. The value is
(-1)^sign * (m / 2^MAN_W) * 2^e. An input is either normalized (the fraction MSB is 1)
or zero (all fields 0). There is no rounding: any bits shifted out during alignment or
normalization are lost. Infinities, NaNs and denormals are not handled.

Operations flow in on a valid/ready stream and out on a valid/ready stream. An operation
transfers on a clock edge when `in_valid` and `in_ready` are both high. A result
transfers when `out_valid` and `out_ready` are both high. When the downstream side holds
`out_ready` low while a result is waiting, the whole pipeline freezes. `in_ready` then
drops, and nothing inside the pipeline moves until the result is taken. Callers must keep
exponents in a range where the normalized result exponent stays between 0 and
2^EXP_W-1. Outside that range the exponent wraps.

Top module: `fpadd_pipe`

## Requirements
- R1: `in_ready` is low exactly when `out_valid` is high and `out_ready` is low. While `out_valid` is high and `out_ready` is low, the output fields and `out_valid` keep their values on the next cycle. No operation or result is lost or duplicated under back-pressure.
- R2: After reset, `out_valid` is 0 and `in_ready` is 1. With `out_ready` held high, an operation accepted before clock edge k is presented after edge k+3, which is a latency of four cycles. Back-to-back operations give one result per clock, in order of acceptance.
- R3: The result exponent is taken from the operand with the larger exponent, then adjusted only by normalization.
- R4: The mantissa of the operand with the smaller exponent is shifted right by the exponent difference, and the bits shifted out are dropped. A difference of `MAN_W` or more makes that operand contribute zero.
- R5: The effective sign of B is `b_sign` XOR `in_sub`. When it equals `a_sign`, the aligned magnitudes are added and the result takes that sign. Otherwise the smaller aligned magnitude is subtracted from the larger, and the result takes the sign of the larger.
- R6: If the magnitude sum carries past the fraction width, the fraction is shifted right by one (its LSB is lost) and the exponent is increased by one.
- R7: If a nonzero result has leading zeros, the fraction is shifted left by the count of leading zeros and the exponent is reduced by that count, so the output fraction MSB is 1.
- R8: A zero magnitude result is output as sign 0, exponent 0, fraction 0.
- R9: A zero operand (all fields 0) leaves the other operand unchanged in the result, apart from the sign effect of `in_sub`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Pipeline can take an operation |
| in_sub | input | 1 | 1 selects A minus B, 0 selects A plus B |
| a_sign | input | 1 | Sign of operand A |
| a_exp | input | EXP_W | Exponent of operand A |
| a_man | input | MAN_W | Fraction of operand A |
| b_sign | input | 1 | Sign of operand B |
| b_exp | input | EXP_W | Exponent of operand B |
| b_man | input | MAN_W | Fraction of operand B |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_sign | output | 1 | Result sign |
| out_exp | output | EXP_W | Result exponent |
| out_man | output | MAN_W | Result fraction |

## Verification
A result is due four clock edges after its operation is accepted, plus one edge for
every cycle the output is stalled. The bench records the cycle count at each acceptance.
During the phase where `out_ready` is held high, it requires that exact gap of four.
During the phases with random back-pressure, it matches results to operations by order
only. All handshake decisions and output comparisons happen 1 ns after the falling
clock edge, when the inputs for the next rising edge are already stable.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  typedef enum logic {
    EFF_ADD = 1'b0,
    EFF_SUB = 1'b1
  } eff_op_e;
endpackage

// File: rtl/fpadd_cmp.sv
module fpadd_cmp #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             in_valid,
  input  logic             in_sub,
  input  logic             a_sign,
  input  logic [EXP_W-1:0] a_exp,
  input  logic [MAN_W-1:0] a_man,
  input  logic             b_sign,
  input  logic [EXP_W-1:0] b_exp,
  input  logic [MAN_W-1:0] b_man,
  output logic             v_q,
  output logic [EXP_W-1:0] exp_q,
  output logic [EXP_W-1:0] shamt_q,
  output logic [MAN_W-1:0] big_man_q,
  output logic [MAN_W-1:0] sml_man_q,
  output logic             big_sign_q,
  output logic             sml_sign_q
);
  logic a_big;
  logic b_eff_sign;

  always_comb begin
    a_big      = (a_exp >= b_exp);
    b_eff_sign = b_sign ^ in_sub;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q        <= 1'b0;
      exp_q      <= '0;
      shamt_q    <= '0;
      big_man_q  <= '0;
      sml_man_q  <= '0;
      big_sign_q <= 1'b0;
      sml_sign_q <= 1'b0;
    end else if (en) begin
      v_q        <= in_valid;
      exp_q      <= a_big ? a_exp : b_exp;
      shamt_q    <= a_big ? (a_exp - b_exp) : (b_exp - a_exp);
      big_man_q  <= a_big ? a_man : b_man;
      sml_man_q  <= a_big ? b_man : a_man;
      big_sign_q <= a_big ? a_sign : b_eff_sign;
      sml_sign_q <= a_big ? b_eff_sign : a_sign;
    end
  end

  AST_EXP_IS_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    en && in_valid |=> exp_q >= $past(a_exp) && exp_q >= $past(b_exp)
                       && (exp_q == $past(a_exp) || exp_q == $past(b_exp))); // R3
endmodule

// File: rtl/fpadd_align.sv
module fpadd_align
  import fpadd_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             v_in,
  input  logic [EXP_W-1:0] exp_in,
  input  logic [EXP_W-1:0] shamt_in,
  input  logic [MAN_W-1:0] big_man_in,
  input  logic [MAN_W-1:0] sml_man_in,
  input  logic             big_sign_in,
  input  logic             sml_sign_in,
  output logic             v_q,
  output logic [EXP_W-1:0] exp_q,
  output logic [MAN_W-1:0] big_q,
  output logic [MAN_W-1:0] sml_q,
  output logic             big_sign_q,
  output logic             sml_sign_q,
  output eff_op_e          op_q
);
  localparam int SHW = (EXP_W > 32) ? EXP_W : 32;

  logic            too_far;
  logic [MAN_W-1:0] shifted;

  always_comb begin
    too_far = (SHW'(shamt_in) >= SHW'(MAN_W));
    shifted = too_far ? '0 : (sml_man_in >> shamt_in);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q        <= 1'b0;
      exp_q      <= '0;
      big_q      <= '0;
      sml_q      <= '0;
      big_sign_q <= 1'b0;
      sml_sign_q <= 1'b0;
      op_q       <= EFF_ADD;
    end else if (en) begin
      v_q        <= v_in;
      exp_q      <= exp_in;
      big_q      <= big_man_in;
      sml_q      <= shifted;
      big_sign_q <= big_sign_in;
      sml_sign_q <= sml_sign_in;
      op_q       <= (big_sign_in ^ sml_sign_in) ? EFF_SUB : EFF_ADD;
    end
  end

  AST_FAR_SHIFT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    en && v_in && (SHW'(shamt_in) >= SHW'(MAN_W)) |=> sml_q == '0); // R4
endmodule

// File: rtl/fpadd_addsub.sv
module fpadd_addsub
  import fpadd_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             v_in,
  input  logic [EXP_W-1:0] exp_in,
  input  logic [MAN_W-1:0] big_in,
  input  logic [MAN_W-1:0] sml_in,
  input  logic             big_sign_in,
  input  logic             sml_sign_in,
  input  eff_op_e          op_in,
  output logic             v_q,
  output logic [EXP_W-1:0] exp_q,
  output logic [MAN_W:0]   sum_q,
  output logic             sign_q
);
  logic [MAN_W:0] sum_n;
  logic           sign_n;

  always_comb begin
    if (op_in == EFF_ADD) begin
      sum_n  = {1'b0, big_in} + {1'b0, sml_in};
      sign_n = big_sign_in;
    end else if (big_in >= sml_in) begin
      sum_n  = {1'b0, big_in - sml_in};
      sign_n = big_sign_in;
    end else begin
      sum_n  = {1'b0, sml_in - big_in};
      sign_n = sml_sign_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q    <= 1'b0;
      exp_q  <= '0;
      sum_q  <= '0;
      sign_q <= 1'b0;
    end else if (en) begin
      v_q    <= v_in;
      exp_q  <= exp_in;
      sum_q  <= sum_n;
      sign_q <= sign_n;
    end
  end

  AST_SUB_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    en && v_in && op_in == EFF_SUB |=> !sum_q[MAN_W]); // R5
  AST_SUB_SIGN_LARGER: assert property (@(posedge clk) disable iff (!rst_n)
    en && v_in && op_in == EFF_SUB && big_in < sml_in |=> sign_q == $past(sml_sign_in)); // R5
endmodule

// File: rtl/fpadd_norm.sv
module fpadd_norm #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             v_in,
  input  logic [EXP_W-1:0] exp_in,
  input  logic [MAN_W:0]   sum_in,
  input  logic             sign_in,
  output logic             v_q,
  output logic [EXP_W-1:0] exp_q,
  output logic [MAN_W-1:0] man_q,
  output logic             sign_q
);
  localparam int LZW = $clog2(MAN_W + 1);

  function automatic logic [LZW-1:0] lead_zeros(input logic [MAN_W-1:0] m);
    logic [LZW-1:0] n;
    n = LZW'(MAN_W);
    for (int i = 0; i < MAN_W; i++) begin
      if (m[i]) n = LZW'(MAN_W - 1 - i);
    end
    return n;
  endfunction

  logic [LZW-1:0]   lz;
  logic [MAN_W-1:0] man_n;
  logic [EXP_W-1:0] exp_n;
  logic             sign_n;

  always_comb begin
    lz = lead_zeros(sum_in[MAN_W-1:0]);
    if (sum_in[MAN_W]) begin
      man_n  = sum_in[MAN_W:1];
      exp_n  = exp_in + EXP_W'(1);
      sign_n = sign_in;
    end else if (sum_in == '0) begin
      man_n  = '0;
      exp_n  = '0;
      sign_n = 1'b0;
    end else begin
      man_n  = sum_in[MAN_W-1:0] << lz;
      exp_n  = exp_in - EXP_W'(lz);
      sign_n = sign_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q    <= 1'b0;
      exp_q  <= '0;
      man_q  <= '0;
      sign_q <= 1'b0;
    end else if (en) begin
      v_q    <= v_in;
      exp_q  <= exp_n;
      man_q  <= man_n;
      sign_q <= sign_n;
    end
  end

  AST_NORM_MSB_SET: assert property (@(posedge clk) disable iff (!rst_n)
    v_q && man_q != '0 |-> man_q[MAN_W-1]); // R7
  AST_ZERO_CANON: assert property (@(posedge clk) disable iff (!rst_n)
    v_q && man_q == '0 |-> exp_q == '0 && !sign_q); // R8
  AST_CARRY_BUMP: assert property (@(posedge clk) disable iff (!rst_n)
    en && v_in && sum_in[MAN_W] |=> exp_q == $past(exp_in) + EXP_W'(1)); // R6
endmodule

// File: rtl/fpadd_pipe.sv
module fpadd_pipe
  import fpadd_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_sub,
  input  logic             a_sign,
  input  logic [EXP_W-1:0] a_exp,
  input  logic [MAN_W-1:0] a_man,
  input  logic             b_sign,
  input  logic [EXP_W-1:0] b_exp,
  input  logic [MAN_W-1:0] b_man,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_sign,
  output logic [EXP_W-1:0] out_exp,
  output logic [MAN_W-1:0] out_man
);
  logic adv;
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  logic             s1_v, s1_bs, s1_ss;
  logic [EXP_W-1:0] s1_exp, s1_sh;
  logic [MAN_W-1:0] s1_big, s1_sml;

  fpadd_cmp #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .en(adv), .in_valid(in_valid), .in_sub(in_sub),
    .a_sign(a_sign), .a_exp(a_exp), .a_man(a_man),
    .b_sign(b_sign), .b_exp(b_exp), .b_man(b_man),
    .v_q(s1_v), .exp_q(s1_exp), .shamt_q(s1_sh), .big_man_q(s1_big),
    .sml_man_q(s1_sml), .big_sign_q(s1_bs), .sml_sign_q(s1_ss)
  );

  logic             s2_v, s2_bs, s2_ss;
  logic [EXP_W-1:0] s2_exp;
  logic [MAN_W-1:0] s2_big, s2_sml;
  eff_op_e          s2_op;

  fpadd_align #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_align (
    .clk(clk), .rst_n(rst_n), .en(adv), .v_in(s1_v), .exp_in(s1_exp),
    .shamt_in(s1_sh), .big_man_in(s1_big), .sml_man_in(s1_sml),
    .big_sign_in(s1_bs), .sml_sign_in(s1_ss),
    .v_q(s2_v), .exp_q(s2_exp), .big_q(s2_big), .sml_q(s2_sml),
    .big_sign_q(s2_bs), .sml_sign_q(s2_ss), .op_q(s2_op)
  );

  logic             s3_v, s3_sign;
  logic [EXP_W-1:0] s3_exp;
  logic [MAN_W:0]   s3_sum;

  fpadd_addsub #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_addsub (
    .clk(clk), .rst_n(rst_n), .en(adv), .v_in(s2_v), .exp_in(s2_exp),
    .big_in(s2_big), .sml_in(s2_sml), .big_sign_in(s2_bs), .sml_sign_in(s2_ss),
    .op_in(s2_op), .v_q(s3_v), .exp_q(s3_exp), .sum_q(s3_sum), .sign_q(s3_sign)
  );

  fpadd_norm #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_norm (
    .clk(clk), .rst_n(rst_n), .en(adv), .v_in(s3_v), .exp_in(s3_exp),
    .sum_in(s3_sum), .sign_in(s3_sign),
    .v_q(out_valid), .exp_q(out_exp), .man_q(out_man), .sign_q(out_sign)
  );

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_man)
                                && $stable(out_exp) && $stable(out_sign)); // R1
  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R1
endmodule

// File: tb/test_fpadd_pipe.sv
module test_fpadd_pipe;
  localparam int EW = 8;
  localparam int MW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, in_sub = 1'b0;
  logic a_sign = 1'b0, b_sign = 1'b0;
  logic [EW-1:0] a_exp = '0, b_exp = '0, out_exp;
  logic [MW-1:0] a_man = '0, b_man = '0, out_man;
  logic out_valid, out_ready = 1'b1, out_sign;

  always #4 clk = ~clk;

  fpadd_pipe #(.EXP_W(EW), .MAN_W(MW)) i_fpadd_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sub(in_sub), .a_sign(a_sign), .a_exp(a_exp), .a_man(a_man),
    .b_sign(b_sign), .b_exp(b_exp), .b_man(b_man),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_sign(out_sign), .out_exp(out_exp), .out_man(out_man)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit lat_mode = 1'b0;
  bit held = 1'b0;
  bit accepted;
  logic [EW+MW:0] held_val;
  logic [EW+MW:0] exp_q[$];
  string tag_q[$];
  int cyc_q[$];
  string cur_tag;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [EW+MW:0] act, input logic [EW+MW:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic logic [EW+MW:0] model(input bit as, input int ae, input int am,
                                           input bit bs, input int be, input int bm,
                                           input bit sub);
    int e;
    longint ma, mb, s;
    bit sg;
    bit sb;
    sb = bs ^ sub;
    if (ae >= be) begin
      e = ae; ma = am; mb = (ae - be >= MW) ? 0 : (bm >> (ae - be));
    end else begin
      e = be; mb = bm; ma = (be - ae >= MW) ? 0 : (am >> (be - ae));
    end
    if (as == sb) begin s = ma + mb; sg = as; end
    else if (ma >= mb) begin s = ma - mb; sg = as; end
    else begin s = mb - ma; sg = sb; end
    if (s == 0) return '0;
    if (s >= (64'd1 << MW)) begin s = s >> 1; e = e + 1; end
    else while (s < (64'd1 << (MW - 1))) begin s = s << 1; e = e - 1; end
    return {sg, EW'(e), MW'(s)};
  endfunction

  task automatic observe();
    logic [EW+MW:0] act;
    act = {out_sign, out_exp, out_man};
    if (held) check(out_valid && act == held_val, "R1", "stalled output changed",
                    act, held_val);
    check(in_ready == !(out_valid && !out_ready), "R1", "in_ready rule",
          {24'd0, in_ready}, {24'd0, !(out_valid && !out_ready)});
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "unexpected result", act, '0);
      end else begin
        logic [EW+MW:0] e;
        string t;
        int c;
        e = exp_q.pop_front(); t = tag_q.pop_front(); c = cyc_q.pop_front();
        check(act == e, t, "result", act, e);
        if (lat_mode) check(cyc - c == 4, "R2", "latency", 25'(cyc - c), 25'd4);
      end
    end
    held = out_valid && !out_ready;
    held_val = act;
    accepted = in_valid && in_ready;
    if (accepted) begin
      exp_q.push_back(model(a_sign, int'(a_exp), int'(a_man), b_sign, int'(b_exp),
                            int'(b_man), in_sub));
      tag_q.push_back(cur_tag);
      cyc_q.push_back(cyc);
    end
  endtask

  task automatic send(input bit as, input int ae, input int am, input bit bs,
                      input int be, input int bm, input bit sub, input string tag,
                      input bit rnd_rdy);
    @(negedge clk);
    a_sign = as; a_exp = EW'(ae); a_man = MW'(am);
    b_sign = bs; b_exp = EW'(be); b_man = MW'(bm);
    in_sub = sub; in_valid = 1'b1; cur_tag = tag;
    out_ready = rnd_rdy ? ($urandom % 4 != 0) : 1'b1;
    #1 observe();
    while (!accepted) begin
      @(negedge clk);
      out_ready = rnd_rdy ? ($urandom % 4 != 0) : 1'b1;
      #1 observe();
    end
  endtask

  task automatic idle(input int n, input bit rnd_rdy);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      out_ready = rnd_rdy ? ($urandom % 2 != 0) : 1'b1;
      #1 observe();
    end
  endtask

  task automatic rand_op(input bit rnd_rdy);
    int ae, be, am, bm, mode;
    bit as, bs;
    ae = 20 + int'($urandom % 200);
    mode = int'($urandom % 4);
    if (mode == 0) be = ae;
    else if (mode == 1) be = ae + int'($urandom % 7) - 3;
    else be = 20 + int'($urandom % 200);
    am = int'({1'b1, 15'($urandom)});
    bm = int'({1'b1, 15'($urandom)});
    as = 1'($urandom); bs = 1'($urandom);
    if ($urandom % 16 == 0) begin ae = 0; am = 0; as = 0; end
    send(as, ae, am, bs, be, bm, 1'($urandom), (ae != be) ? "R3" : "R5", rnd_rdy);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed;
    seed = int'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    check(out_valid == 1'b0, "R2", "out_valid in reset", {24'd0, out_valid}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(out_valid == 1'b0 && in_ready == 1'b1, "R2", "state after reset",
          {23'd0, out_valid, in_ready}, 25'd1);

    lat_mode = 1'b1;
    send(0, 100, 'hC000, 0, 100, 'hC000, 0, "R6", 0);  // carry: C000 e101
    send(0, 80, 'hA5A5, 0, 80, 'hA5A5, 1, "R8", 0);    // exact cancel -> zero
    send(0, 50, 'h8001, 0, 50, 'h8000, 1, "R7", 0);    // one bit left -> 8000 e35
    send(0, 100, 'h9000, 0, 80, 'hFFFF, 0, "R4", 0);   // diff 20 -> drops b
    send(0, 100, 'h9000, 0, 84, 'hFFFF, 0, "R4", 0);   // diff 16 -> drops b
    send(0, 100, 'h9000, 0, 85, 'h8000, 0, "R4", 0);   // diff 15 -> adds 1
    send(0, 50, 'h8000, 0, 50, 'hC000, 1, "R5", 0);    // larger b wins sign
    send(0, 0, 0, 1, 77, 'hB00B, 0, "R9", 0);          // zero operand
    send(0, 40, 'h8000, 0, 42, 'h8000, 0, "R3", 0);    // b exponent chosen
    send(0, 60, 'h8000, 1, 60, 'h8000, 1, "R5", 0);    // minus negative adds
    for (int i = 0; i < 40; i++) rand_op(0);
    idle(6, 0);
    lat_mode = 1'b0;

    for (int i = 0; i < 400; i++) begin
      rand_op(1);
      if ($urandom % 8 == 0) idle(1, 1);
    end
    idle(12, 0);
    check(exp_q.size() == 0, "R1", "results outstanding after drain",
          25'(exp_q.size()), '0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule